// File: doc/BRIEF.md
# USB Host Status Event Register

This block holds the four sticky event flags that a USB 2.0 host controller reports to its driver. Each flag has its own capture rule. The frame-list wrap flag sets when the top bit of the 14-bit frame index changes level. The port-change flag sets on a rising edge of any change indicator of a port this controller owns. The error flag and the completion flag are driven by qualified completion pulses from the transfer engine.

Software reads the flags as a 4-bit word. It clears any subset of them by writing ones at those positions. Bit positions are fixed: bit 0 is completion, bit 1 is error, bit 2 is port change and bit 3 is frame wrap. A per-bit enable mask selects which flags drive the interrupt line, and that line is registered.

Top module: `hc_evt_status`

## Requirements
- R1: While `rst` is high at a clock edge, every flag and `irq` become 0. The frame-index top bit and the port change bits present during reset are taken as the baseline, so levels that are already high at release are not counted as events.
- R2: Bit 3 of `flags` reads 1 after the first clock edge at which `frame_idx[13]` differs from its value at the previous edge. This applies to a change in either direction. Changes on the lower index bits never set it.
- R3: Bit 2 sets on the next edge when any port with `port_owner` 0 shows a 0-to-1 transition on its connect, enable or overcurrent change input.
- R4: Bit 2 also sets when the force-resume input of a port with `port_owner` 0 goes from 0 to 1.
- R5: A port whose `port_owner` bit is 1 never sets bit 2, whatever its inputs do.
- R6: Bit 1 sets on the edge after a cycle with `xfer_done` and `xfer_err` both high.
- R7: Bit 0 sets on the edge after a cycle with `xfer_done` high and either `xfer_ioc` or `xfer_short` high. When `xfer_err` and `xfer_ioc` are high together in such a completion, bits 1 and 0 set at the same edge.
- R8: The `xfer_ioc`, `xfer_short` and `xfer_err` inputs have no effect unless `xfer_done` is high.
- R9: A cycle with `wr_en` high clears each flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 keep their value.
- R10: If a set event and a clear hit the same flag at the same edge, the flag ends up at 1.
- R11: `irq` equals the OR over i of `flags[i] & irq_en[i]` as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_idx | input | FIDX_W | Current frame index |
| port_conn_chg | input | NPORTS | Per-port connect-change indicator |
| port_en_chg | input | NPORTS | Per-port enable-change indicator |
| port_oc_chg | input | NPORTS | Per-port overcurrent-change indicator |
| port_force_res | input | NPORTS | Per-port force-resume indicator |
| port_owner | input | NPORTS | 1 = port handed to another controller |
| xfer_done | input | 1 | Transaction completion pulse |
| xfer_ioc | input | 1 | Completed descriptor requested an interrupt |
| xfer_short | input | 1 | Completion received fewer bytes than expected |
| xfer_err | input | 1 | Completion ended in an error |
| wr_en | input | 1 | Clear strobe |
| wr_data | input | 4 | Ones select the flags to clear |
| irq_en | input | 4 | Per-flag interrupt enable |
| flags | output | 4 | Flag word: bit 3 wrap, bit 2 port, bit 1 error, bit 0 completion |
| irq | output | 1 | Registered interrupt request |

## Verification
A capture event and a software clear of the same flag can land on the same clock edge. This collision is provoked on purpose, with a completion pulse carrying the IOC qualifier in the same cycle as a write that clears bit 0. The flag must read 1 afterwards. Random traffic later overlaps clears with frame wraps, port edges and completions, and a behavioural model that applies clears before sets judges every cycle.

// File: rtl/hc_evt_pkg.sv
package hc_evt_pkg;
  localparam int NFLAGS   = 4;
  localparam int FLG_XFER = 0;
  localparam int FLG_ERR  = 1;
  localparam int FLG_PORT = 2;
  localparam int FLG_ROLL = 3;
  typedef logic [NFLAGS-1:0] flags_t;
endpackage

// File: rtl/hc_roll_detect.sv
// Flags a level change of the frame index wrap bit.
module hc_roll_detect (
  input  logic clk,
  input  logic rst,
  input  logic wrap_bit,
  output logic roll_evt
);
  logic prev_q;

  // Reset loads the live level, so it becomes the baseline.
  always_ff @(posedge clk) begin
    prev_q <= wrap_bit;
  end

  assign roll_evt = !rst && (wrap_bit != prev_q);
endmodule

// File: rtl/hc_port_chg_detect.sv
// Rising-edge detection over the change indicators of every owned port.
module hc_port_chg_detect #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] conn_chg,
  input  logic [NPORTS-1:0] en_chg,
  input  logic [NPORTS-1:0] oc_chg,
  input  logic [NPORTS-1:0] force_res,
  input  logic [NPORTS-1:0] owner,
  output logic              chg_evt
);
  localparam int NSRC = 4;

  logic [NPORTS-1:0] hit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [NSRC-1:0] cur;
    logic [NSRC-1:0] prev_q;
    assign cur = {force_res[p], oc_chg[p], en_chg[p], conn_chg[p]};
    always_ff @(posedge clk) begin
      prev_q <= cur;
    end
    assign hit[p] = !owner[p] && (|(cur & ~prev_q));
  end

  assign chg_evt = !rst && (|hit);
endmodule

// File: rtl/hc_w1c_flag.sv
// One sticky flag: write-one clear, set has priority.
module hc_w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/hc_evt_status.sv
module hc_evt_status
  import hc_evt_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int FIDX_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic [NPORTS-1:0] port_conn_chg,
  input  logic [NPORTS-1:0] port_en_chg,
  input  logic [NPORTS-1:0] port_oc_chg,
  input  logic [NPORTS-1:0] port_force_res,
  input  logic [NPORTS-1:0] port_owner,
  input  logic              xfer_done,
  input  logic              xfer_ioc,
  input  logic              xfer_short,
  input  logic              xfer_err,
  input  logic              wr_en,
  input  logic [NFLAGS-1:0] wr_data,
  input  logic [NFLAGS-1:0] irq_en,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  localparam int WRAP_BIT = FIDX_W - 1;

  logic   roll_evt;
  logic   port_evt;
  flags_t set_v;
  flags_t clr_v;
  logic   unused_fidx_lo;

  assign unused_fidx_lo = ^frame_idx[WRAP_BIT-1:0];

  hc_roll_detect u_roll (
    .clk     (clk),
    .rst     (rst),
    .wrap_bit(frame_idx[WRAP_BIT]),
    .roll_evt(roll_evt)
  );

  hc_port_chg_detect #(.NPORTS(NPORTS)) u_port (
    .clk      (clk),
    .rst      (rst),
    .conn_chg (port_conn_chg),
    .en_chg   (port_en_chg),
    .oc_chg   (port_oc_chg),
    .force_res(port_force_res),
    .owner    (port_owner),
    .chg_evt  (port_evt)
  );

  assign set_v[FLG_ROLL] = roll_evt;
  assign set_v[FLG_PORT] = port_evt;
  assign set_v[FLG_ERR]  = xfer_done && xfer_err;
  assign set_v[FLG_XFER] = xfer_done && (xfer_ioc || xfer_short);
  assign clr_v           = wr_en ? wr_data : '0;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    hc_w1c_flag u_flag (
      .clk(clk),
      .rst(rst),
      .set(set_v[i]),
      .clr(clr_v[i]),
      .q  (flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & irq_en);
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == '0) && !irq);
  a_r2_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (frame_idx[WRAP_BIT] != $past(frame_idx[WRAP_BIT])) |=> flags[FLG_ROLL]);
  a_r3_port0_conn_edge: assert property (@(posedge clk) disable iff (rst)
    (!port_owner[0] && port_conn_chg[0] && !$past(port_conn_chg[0]))
      |=> flags[FLG_PORT]);
  a_r4_port0_resume_edge: assert property (@(posedge clk) disable iff (rst)
    (!port_owner[0] && port_force_res[0] && !$past(port_force_res[0]))
      |=> flags[FLG_PORT]);
  a_r5_owned_ports_silent: assert property (@(posedge clk) disable iff (rst)
    ((&port_owner) && !flags[FLG_PORT]) |=> !flags[FLG_PORT]);
  a_r6_error_sets: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && xfer_err) |=> flags[FLG_ERR]);
  a_r7_complete_sets: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && (xfer_ioc || xfer_short)) |=> flags[FLG_XFER]);
  a_r8_no_done_no_error: assert property (@(posedge clk) disable iff (rst)
    (!xfer_done && !flags[FLG_ERR]) |=> !flags[FLG_ERR]);
  a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flags & irq_en))));
endmodule

// File: tb/hc_evt_status_tb.sv
`timescale 1ns/1ps
module hc_evt_status_tb_top;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [13:0]   frame_idx = '0;
  logic [NP-1:0] conn = '0, enc = '0, occ = '0, fres = '0, owner = '0;
  logic          done = 0, ioc = 0, shrt = 0, err = 0;
  logic          wr_en = 0;
  logic [3:0]    wr_data = '0, irq_en = '0;
  logic [3:0]    flags;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hc_evt_status #(.NPORTS(NP), .FIDX_W(14)) dut_i (
    .clk(clk), .rst(rst), .frame_idx(frame_idx),
    .port_conn_chg(conn), .port_en_chg(enc), .port_oc_chg(occ),
    .port_force_res(fres), .port_owner(owner),
    .xfer_done(done), .xfer_ioc(ioc), .xfer_short(shrt), .xfer_err(err),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .flags(flags), .irq(irq)
  );

  // Behavioural reference: clears first, then events, interrupt one cycle late.
  logic [3:0]    exp_flags = '0;
  logic          exp_irq = 0;
  logic          m_b13 = 0;
  logic [NP-1:0] m_conn = '0, m_en = '0, m_oc = '0, m_fr = '0;

  always @(posedge clk) begin
    logic [3:0] nxt;
    if (rst) begin
      exp_flags <= '0;
      exp_irq   <= 1'b0;
    end else begin
      nxt = exp_flags;
      if (wr_en) nxt = nxt & ~wr_data;
      if (frame_idx[13] != m_b13) nxt[3] = 1'b1;
      for (int p = 0; p < NP; p++) begin
        if (!owner[p] && ((conn[p] && !m_conn[p]) || (enc[p] && !m_en[p]) ||
                          (occ[p] && !m_oc[p]) || (fres[p] && !m_fr[p])))
          nxt[2] = 1'b1;
      end
      if (done && err) nxt[1] = 1'b1;
      if (done && (ioc || shrt)) nxt[0] = 1'b1;
      exp_flags <= nxt;
      exp_irq   <= |(exp_flags & irq_en);
    end
    m_b13  <= frame_idx[13];
    m_conn <= conn; m_en <= enc; m_oc <= occ; m_fr <= fres;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  // Compare against the model on every cycle, at the falling edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(flags[3] == exp_flags[3], "R2 wrap flag vs model", flags[3], exp_flags[3]);
      chk(flags[2] == exp_flags[2], "R3 port flag vs model", flags[2], exp_flags[2]);
      chk(flags[1] == exp_flags[1], "R6 error flag vs model", flags[1], exp_flags[1]);
      chk(flags[0] == exp_flags[0], "R7 completion flag vs model", flags[0], exp_flags[0]);
      chk(irq == exp_irq, "R11 irq vs model", irq, exp_irq);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 4'hF;
    step();
    wr_en = 0; wr_data = 4'h0;
  endtask

  initial begin
    frame_idx = 14'h2000;
    repeat (3) step();
    chk(flags == 4'h0 && irq == 1'b0, "R1 reset state", {irq, flags}, 0);
    rst = 0;
    step();
    chk(flags == 4'h0, "R1 baseline high wrap bit is no event", flags, 0);

    frame_idx = 14'h0000; step();
    chk(flags == 4'h8, "R2 wrap bit fall sets bit 3", flags, 8);
    wr_en = 1; wr_data = 4'h8; step(); wr_en = 0; wr_data = 0;
    chk(flags == 4'h0, "R9 write one clears bit 3", flags, 0);
    frame_idx = 14'h1FFF; step();
    chk(flags == 4'h0, "R2 low index bits do not set", flags, 0);
    frame_idx = 14'h2000; step();
    chk(flags == 4'h8, "R2 wrap bit rise sets bit 3", flags, 8);
    clear_all();

    conn[0] = 1; step();
    chk(flags == 4'h4, "R3 connect change edge sets bit 2", flags, 4);
    clear_all(); step();
    chk(flags == 4'h0, "R3 held level is no new edge", flags, 0);
    conn[0] = 0; occ[3] = 1; step();
    chk(flags == 4'h4, "R3 overcurrent change edge sets bit 2", flags, 4);
    occ[3] = 0; clear_all();

    owner[1] = 1; conn[1] = 1; enc[1] = 1; fres[1] = 1; step();
    chk(flags == 4'h0, "R5 owned port ignored", flags, 0);
    conn[1] = 0; enc[1] = 0; fres[1] = 0; owner[1] = 0; step();

    fres[2] = 1; step();
    chk(flags == 4'h4, "R4 force resume rise sets bit 2", flags, 4);
    fres[2] = 0; clear_all();

    ioc = 1; err = 1; shrt = 1; step();
    chk(flags == 4'h0, "R8 qualifiers without done ignored", flags, 0);
    shrt = 0; done = 1; step();
    chk(flags == 4'h3, "R7 error with ioc sets bits 1 and 0", flags, 3);
    done = 0; ioc = 0; err = 0;
    wr_en = 1; wr_data = 4'h1; step(); wr_en = 0; wr_data = 0;
    chk(flags == 4'h2, "R9 zero bits leave flags alone", flags, 2);
    done = 1; err = 1; step();
    chk(flags == 4'h2, "R6 error only sets bit 1", flags, 2);
    done = 0; err = 0; clear_all();

    done = 1; shrt = 1; step();
    chk(flags == 4'h1, "R7 short packet sets bit 0", flags, 1);
    shrt = 0; ioc = 1; wr_en = 1; wr_data = 4'h1; step();
    chk(flags == 4'h1, "R10 set beats clear", flags, 1);
    done = 0; ioc = 0; wr_en = 0; wr_data = 0;

    irq_en = 4'h1; step();
    chk(irq == 1'b1, "R11 irq rises a cycle after enable", irq, 1);
    wr_en = 1; wr_data = 4'h1; step(); wr_en = 0; wr_data = 0;
    chk(irq == 1'b1 && flags == 4'h0, "R11 irq lags the clear", {irq, flags}, 16);
    step();
    chk(irq == 1'b0, "R11 irq drops", irq, 0);
    irq_en = 4'h2; done = 1; ioc = 1; step(); done = 0; ioc = 0; step();
    chk(irq == 1'b0, "R11 masked flag gives no irq", irq, 0);
    clear_all();

    for (int n = 0; n < 3000; n++) begin
      frame_idx = frame_idx + 14'($urandom_range(0, 1500));
      conn  = NP'($urandom); enc = NP'($urandom);
      occ   = NP'($urandom); fres = NP'($urandom);
      owner = NP'($urandom);
      done  = ($urandom_range(0, 3) == 0);
      ioc   = $urandom_range(0, 1); shrt = $urandom_range(0, 1);
      err   = ($urandom_range(0, 2) == 0);
      wr_en = ($urandom_range(0, 2) == 0); wr_data = 4'($urandom);
      if ($urandom_range(0, 15) == 0) irq_en = 4'($urandom);
      step();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule